// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block closes out a floating-point operation. When an operation finishes, the datapath presents the five exception flags it raised, together with the present value of the floating-point status word and the program-counter pair of the instruction. The block compares the flags with the trap-enable mask held in the status word. From that it decides whether the operation traps, and it produces the updated status word, the next program-counter pair and a one-cycle trap pulse.

On a trap, the enabled flags are reduced to a single flag by a fixed priority. The accrued field is left as it was, and the program-counter pair stays where it is, so the instruction can be handled again. Without a trap, the raised flags become the current field and are also added to the accrued field. The program counter then steps past the instruction.

The completion interface has a valid strobe and no ready. The block accepts one completion on every cycle in which `done_valid_i` is high and never applies back-pressure. Each accepted completion updates the outputs on the next rising clock edge. Between completions the outputs hold their values.

Top module: `fpx_status_unit`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `status_o`, `pc_o` and `npc_o` are zero and `trap_o` is low.
- R2: A completion traps exactly when the raised flags ANDed with the enable mask (`status_i[27:23]`) are nonzero. `trap_o` is high for one cycle, on the clock edge that follows the valid strobe.
- R3: On a trap, `status_o[4:0]` holds only the highest-priority flag that is both raised and enabled. The flag positions, which are the same in the mask, current and accrued fields, are bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact. The priority order is bit 4 highest, then 3, 2, 1, and bit 0 lowest.
- R4: Without a trap, `status_o[4:0]` is overwritten with the raised flags exactly, so a completion with no flags clears it.
- R5: The accrued field `status_o[9:5]` equals `status_i[9:5]` ORed with the raised flags when there is no trap, and equals `status_i[9:5]` unchanged on a trap.
- R6: The trap-type field `status_o[16:14]` becomes 1 on a trap and 0 on every completion without a trap.
- R7: Without a trap, `pc_o` takes `npc_i` and `npc_o` takes `npc_i + 4`, with the addition wrapping at the register width. On a trap, `pc_o` takes `pc_i` and `npc_o` takes `npc_i`.
- R8: All other status bits, including the enable mask, pass from `status_i` to `status_o` unchanged.
- R9: In a cycle with `done_valid_i` low, all outputs keep their values and `trap_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_valid_i | input | 1 | A floating-point operation completes this cycle |
| raised_i | input | 5 | Exception flags raised by the operation |
| status_i | input | SR_W (32) | Present status word, including the trap-enable mask |
| pc_i | input | PC_W (64) | Program counter of the completing instruction |
| npc_i | input | PC_W (64) | Next program counter of the completing instruction |
| status_o | output | SR_W (32) | Updated status word |
| pc_o | output | PC_W (64) | Program counter after the completion |
| npc_o | output | PC_W (64) | Next program counter after the completion |
| trap_o | output | 1 | One-cycle pulse: the completion traps |

## Verification
The in-line assertions check the following on every cycle:
- the trap pulse follows exactly the enabled-flag condition;
- a trap leaves one current flag, the old accrued field and the old program-counter pair;
- a non-trapping step moves the next program counter by four;
- the outputs stay still while no completion is presented.

Some behaviour only the bench scenarios can show. These are which flag wins when several enabled flags collide, the exact merged accrued value, pass-through of the unrelated status bits, and wrap-around of the next program counter.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned FLAG_W  = 5;
  localparam int unsigned CUR_LSB = 0;
  localparam int unsigned ACC_LSB = 5;
  localparam int unsigned TT_LSB  = 14;
  localparam int unsigned TT_W    = 3;
  localparam int unsigned EN_LSB  = 23;
  localparam int unsigned SR_MIN  = EN_LSB + FLAG_W;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;
  localparam logic [TT_W-1:0] TT_NONE = 3'd0;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/fpx_trap_pick.sv
module fpx_trap_pick
  import fpx_pkg::*;
(
  input  flags_t raised_i,
  input  flags_t enable_i,
  output logic   trap_o,
  output flags_t result_o
);
  flags_t masked;
  flags_t winner;
  logic   seen;

  assign masked = raised_i & enable_i;
  assign trap_o = |masked;

  // Highest bit wins: invalid > overflow > underflow > divzero > inexact
  always_comb begin
    winner = '0;
    seen   = 1'b0;
    for (int i = FLAG_W - 1; i >= 0; i--) begin
      if (masked[i] && !seen) begin
        winner[i] = 1'b1;
        seen      = 1'b1;
      end
    end
  end

  assign result_o = trap_o ? winner : raised_i;

  always_comb begin
    if (trap_o) a_r3_single_winner: assert ($countones(result_o) == 1);
  end
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge
  import fpx_pkg::*;
#(
  parameter int unsigned SR_W = 32
) (
  input  logic [SR_W-1:0] status_i,
  input  logic            trap_i,
  input  flags_t          result_i,
  output logic [SR_W-1:0] status_o
);
  flags_t acc_old;
  assign acc_old = status_i[ACC_LSB +: FLAG_W];

  always_comb begin
    status_o = status_i;
    status_o[CUR_LSB +: FLAG_W] = result_i;
    status_o[ACC_LSB +: FLAG_W] = trap_i ? acc_old : (acc_old | result_i);
    status_o[TT_LSB +: TT_W]    = trap_i ? TT_IEEE : TT_NONE;
  end
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
  parameter int unsigned PC_W = 64,
  parameter int unsigned STEP = 4
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  input  logic            trap_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  assign pc_o  = trap_i ? pc_i  : npc_i;
  assign npc_o = trap_i ? npc_i : npc_i + STEP_V;
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int unsigned SR_W = 32,
  parameter int unsigned PC_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_valid_i,
  input  logic [4:0]      raised_i,
  input  logic [SR_W-1:0] status_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  output logic [SR_W-1:0] status_o,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o,
  output logic            trap_o
);
  logic            trap_c;
  flags_t          result_c;
  logic [SR_W-1:0] status_c;
  logic [PC_W-1:0] pc_c, npc_c;

  fpx_trap_pick u_pick (
    .raised_i (raised_i),
    .enable_i (status_i[EN_LSB +: FLAG_W]),
    .trap_o   (trap_c),
    .result_o (result_c)
  );

  fpx_status_merge #(.SR_W(SR_W)) u_merge (
    .status_i (status_i),
    .trap_i   (trap_c),
    .result_i (result_c),
    .status_o (status_c)
  );

  fpx_pc_step #(.PC_W(PC_W), .STEP(4)) u_step (
    .pc_i   (pc_i),
    .npc_i  (npc_i),
    .trap_i (trap_c),
    .pc_o   (pc_c),
    .npc_o  (npc_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      pc_o     <= '0;
      npc_o    <= '0;
      trap_o   <= 1'b0;
    end else begin
      trap_o <= done_valid_i & trap_c;
      if (done_valid_i) begin
        status_o <= status_c;
        pc_o     <= pc_c;
        npc_o    <= npc_c;
      end
    end
  end

  // R2: trap pulse follows the enabled-flag condition
  a_r2_trap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid_i |=> (trap_o == $past(|(raised_i & status_i[EN_LSB +: FLAG_W]))));

  // R3: a trap leaves exactly one current flag
  a_r3_one_current: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($countones(status_o[CUR_LSB +: FLAG_W]) == 1));

  // R5: accrued field untouched on a trap
  a_r5_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (status_o[ACC_LSB +: FLAG_W] == $past(status_i[ACC_LSB +: FLAG_W])));

  // R7: PC pair held on a trap
  a_r7_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (pc_o == $past(pc_i) && npc_o == $past(npc_i)));

  // R7: non-trapping completion steps by four
  a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid_i && !(|(raised_i & status_i[EN_LSB +: FLAG_W])))
      |=> (npc_o == pc_o + PC_W'(4)));

  // R9: idle cycles hold outputs and raise no trap
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid_i |=> (!trap_o && $stable(status_o) && $stable(pc_o) && $stable(npc_o)));
endmodule

// File: tb/fpx_status_unit_tb.sv
module fpx_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {enable[25:21], raised[20:16], acc_in[15:11], exp_cur[10:6], exp_acc[5:1], exp_trap[0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 1'b0},
    {5'b00000, 5'b10001, 5'b00010, 5'b10001, 5'b10011, 1'b0},
    {5'b11111, 5'b01100, 5'b00001, 5'b01000, 5'b00001, 1'b1},
    {5'b00100, 5'b01100, 5'b00000, 5'b00100, 5'b00000, 1'b1},
    {5'b00011, 5'b11100, 5'b00001, 5'b11100, 5'b11101, 1'b0},
    {5'b11111, 5'b11111, 5'b01010, 5'b10000, 5'b01010, 1'b1},
    {5'b00011, 5'b00011, 5'b00000, 5'b00010, 5'b00000, 1'b1},
    {5'b00001, 5'b00001, 5'b11110, 5'b00001, 5'b11110, 1'b1},
    {5'b10000, 5'b00001, 5'b11110, 5'b00001, 5'b11111, 1'b0},
    {5'b01000, 5'b00000, 5'b10101, 5'b00000, 5'b10101, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_valid_i = 1'b0;
  logic [4:0]  raised_i = '0;
  logic [31:0] status_i = '0;
  logic [63:0] pc_i = '0, npc_i = '0;
  logic [31:0] status_o;
  logic [63:0] pc_o, npc_o;
  logic        trap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .done_valid_i(done_valid_i), .raised_i(raised_i),
    .status_i(status_i), .pc_i(pc_i), .npc_i(npc_i),
    .status_o(status_o), .pc_o(pc_o), .npc_o(npc_o), .trap_o(trap_o)
  );

  // Word layout: [31:28] spare, [27:23] enable, [22:17] spare, [16:14] trap type,
  // [13:10] spare, [9:5] accrued, [4:0] current
  function automatic logic [31:0] sr(input logic [4:0] en, input logic [2:0] tt,
                                     input logic [4:0] acc, input logic [4:0] cur);
    return {4'hA, en, 6'b101101, tt, 4'b1001, acc, cur};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] fl, input logic [31:0] st,
                       input logic [63:0] p, input logic [63:0] np);
    @(negedge clk);
    done_valid_i = 1'b1; raised_i = fl; status_i = st; pc_i = p; npc_i = np;
    @(negedge clk);
    done_valid_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status in reset", 64'(status_o), 64'h0);
    chk("R1 trap in reset", 64'(trap_o), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset", pc_o, 64'h0);
    chk("R1 npc after reset", npc_o, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] en, fl, ai, ec, ea;
      logic et;
      logic [63:0] p;
      {en, fl, ai, ec, ea, et} = VEC[i];
      p = 64'h1000 + 64'(i) * 64'h10;
      apply(fl, sr(en, 3'b110, ai, 5'b01011), p, p + 64'd4);
      chk("R2 trap pulse", 64'(trap_o), 64'(et));
      chk(et ? "R3/R5/R6/R8 status on trap" : "R4/R5/R6/R8 status no trap",
          64'(status_o), 64'(sr(en, et ? 3'b001 : 3'b000, ea, ec)));
      chk("R7 pc", pc_o, et ? p : p + 64'd4);
      chk("R7 npc", npc_o, et ? p + 64'd4 : p + 64'd8);
    end

    // R9: idle cycles with changing inputs hold outputs; trap is a single pulse
    apply(5'b10000, sr(5'b10000, 3'b000, 5'b0, 5'b0), 64'h2000, 64'h2004);
    chk("R2 trap set", 64'(trap_o), 64'h1);
    raised_i = 5'b11111; status_i = 32'hFFFF_FFFF; pc_i = 64'h9; npc_i = 64'h7;
    @(negedge clk);
    chk("R9 trap low when idle", 64'(trap_o), 64'h0);
    chk("R9 status held", 64'(status_o), 64'(sr(5'b10000, 3'b001, 5'b0, 5'b10000)));
    chk("R9 pc held", pc_o, 64'h2000);
    chk("R9 npc held", npc_o, 64'h2004);

    // R7: npc wraps at register width
    apply(5'b00000, sr(5'b0, 3'b0, 5'b0, 5'b0), 64'hFFFF_FFFF_FFFF_FFF8,
          64'hFFFF_FFFF_FFFF_FFFC);
    chk("R7 pc wrap", pc_o, 64'hFFFF_FFFF_FFFF_FFFC);
    chk("R7 npc wrap", npc_o, 64'h0);

    // R4: back-to-back completions overwrite current field each time
    @(negedge clk);
    done_valid_i = 1'b1; raised_i = 5'b00110; status_i = sr(5'b0, 3'b0, 5'b0, 5'b0);
    pc_i = 64'h40; npc_i = 64'h44;
    @(negedge clk);
    raised_i = 5'b00001; status_i = sr(5'b0, 3'b0, 5'b00110, 5'b00110);
    pc_i = 64'h44; npc_i = 64'h48;
    @(negedge clk);
    done_valid_i = 1'b0;
    chk("R4 second overwrite", 64'(status_o), 64'(sr(5'b0, 3'b0, 5'b00111, 5'b00001)));
    chk("R7 back-to-back npc", npc_o, 64'h4C);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 status after re-reset", 64'(status_o), 64'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule